// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block divides a synthesizer's oscillator clock by a programmable integer N. It produces one pulse every N input clocks, and that pulse goes to a phase/frequency comparator. The divider uses the classic two-counter scheme. A prescaler divides either by 16 or by 17. A swallow counter sets how many prescaler cycles in each output period use the longer modulus. A main counter sets how many prescaler cycles make up the whole period. This gives N = 16·M + A, where A is the four low bits of the ratio and M is the remaining upper bits. The prescaler is modelled as ordinary synchronous logic on the same clock.

The 15-bit ratio arrives as two bytes, each with its own write strobe. One byte carries the 7 upper bits and the other carries the 8 lower bits. A new ratio is only accepted once both bytes have been written since the last acceptance. They may be written in either order, or in the same cycle. The accepted ratio then waits in a staging register. The divider loads it at the end of the output period that is running, so no period is ever cut short or stretched. Ratios below 240 are raised to 240 when they are accepted. The floor of 240 makes sure M is always at least as large as A.

Top module: `pswallow_div`

## Requirements
- R1: While reset is high, `div_pulse` is 0. After reset the ratio is 240, so the first pulse appears 240 clocks after the first clock edge at which reset is low.
- R2: `div_pulse` is high for exactly one clock. Once a ratio N is in force, successive pulses are exactly N clocks apart.
- R3: The period is built as M prescaler cycles. The first A of these last 17 clocks and the rest last 16 clocks, where A = ratio bits [3:0] and M = ratio bits [14:4]. Ratios with A = 0 and A = 15 both give a period of exactly 16·M + A.
- R4: `hi_data` supplies ratio bits [14:8] and `lo_data` supplies ratio bits [7:0].
- R5: A ratio is accepted only after both bytes have been written since the previous acceptance. Either order is allowed, and so is a write of both bytes in the same cycle. Writing only one byte leaves the pulse spacing unchanged.
- R6: If the same byte is written more than once before acceptance, the last value written is the one used.
- R7: An accepted ratio first applies to the period that begins after the current period ends. The current period completes with the old ratio. If two ratios are accepted within one period, the later one applies.
- R8: An accepted ratio below 240 is replaced by 240.
- R9: The largest ratio, 32767, gives pulses 32767 clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock being divided |
| rst | input | 1 | Synchronous active-high reset |
| hi_wr | input | 1 | Write strobe for the upper ratio byte |
| hi_data | input | 7 | Ratio bits [14:8] |
| lo_wr | input | 1 | Write strobe for the lower ratio byte |
| lo_data | input | 8 | Ratio bits [7:0] |
| div_pulse | output | 1 | One-clock pulse once per divided period |

## Verification
The bench builds the block with its default parameters: a 15-bit ratio, an 8-bit low byte, a 4-bit swallow field and a floor of 240. With these defaults, both ends of the legal range can be reached. The 32767 extreme takes about 33 thousand clocks, and the 240 floor is reached both directly and through clamping. The chosen ratios have swallow fields of 0 and 15, so the bench shows that every period with the longer modulus is counted. A scoreboard predicts each pulse spacing from the write sequence, including writes of a single byte, repeated writes of one byte, and two acceptances within one period.

// File: rtl/psd_pkg.sv
package psd_pkg;
  localparam int unsigned PSD_RATIO_W   = 15;
  localparam int unsigned PSD_LO_W      = 8;
  localparam int unsigned PSD_SWALLOW_W = 4;
  localparam int unsigned PSD_MIN_RATIO = 240;

  typedef enum logic {
    MOD_LOW  = 1'b0,
    MOD_HIGH = 1'b1
  } psd_mod_e;
endpackage

// File: rtl/psd_ratio_stage.sv
module psd_ratio_stage
  import psd_pkg::*;
#(
  parameter int unsigned RATIO_W   = PSD_RATIO_W,
  parameter int unsigned LO_W      = PSD_LO_W,
  parameter int unsigned MIN_RATIO = PSD_MIN_RATIO,
  localparam int unsigned HI_W     = RATIO_W - LO_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hi_wr,
  input  logic [HI_W-1:0]    hi_data,
  input  logic               lo_wr,
  input  logic [LO_W-1:0]    lo_data,
  input  logic               take,
  output logic               stg_valid,
  output logic [RATIO_W-1:0] stg_ratio
);
  localparam logic [RATIO_W-1:0] FLOOR = RATIO_W'(MIN_RATIO);

  logic [HI_W-1:0]    hold_hi;
  logic [LO_W-1:0]    hold_lo;
  logic               seen_hi, seen_lo;
  logic [HI_W-1:0]    hi_now;
  logic [LO_W-1:0]    lo_now;
  logic               commit;
  logic [RATIO_W-1:0] joined;
  logic [RATIO_W-1:0] floored;

  always_comb begin
    hi_now  = hi_wr ? hi_data : hold_hi;
    lo_now  = lo_wr ? lo_data : hold_lo;
    commit  = (seen_hi || hi_wr) && (seen_lo || lo_wr);
    joined  = {hi_now, lo_now};
    floored = (joined < FLOOR) ? FLOOR : joined;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_hi   <= '0;
      hold_lo   <= '0;
      seen_hi   <= 1'b0;
      seen_lo   <= 1'b0;
      stg_valid <= 1'b0;
      stg_ratio <= FLOOR;
    end else begin
      hold_hi <= hi_now;
      hold_lo <= lo_now;
      if (commit) begin
        seen_hi   <= 1'b0;
        seen_lo   <= 1'b0;
        stg_valid <= 1'b1;
        stg_ratio <= floored;
      end else begin
        seen_hi <= seen_hi || hi_wr;
        seen_lo <= seen_lo || lo_wr;
        if (take) stg_valid <= 1'b0;
      end
    end
  end

  // R8: anything staged respects the floor
  p_staged_floor_r8: assert property (@(posedge clk) disable iff (rst)
    stg_valid |-> (stg_ratio >= FLOOR));

  // R5: staging only becomes valid in response to a write strobe
  p_commit_cause_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(stg_valid) |-> $past(hi_wr || lo_wr));

  // R5: a lone upper byte with no lower byte pending stages nothing new
  p_lone_byte_r5: assert property (@(posedge clk) disable iff (rst)
    (hi_wr && !lo_wr && !seen_lo) |=> (stg_ratio == $past(stg_ratio)));
endmodule

// File: rtl/psd_prescaler.sv
module psd_prescaler
  import psd_pkg::*;
#(
  parameter int unsigned SWALLOW_W = PSD_SWALLOW_W,
  localparam int unsigned CNT_W    = SWALLOW_W + 1
) (
  input  logic     clk,
  input  logic     rst,
  input  psd_mod_e mod_sel,
  output logic     carry
);
  localparam logic [CNT_W-1:0] TERM_LO = CNT_W'((1 << SWALLOW_W) - 1);
  localparam logic [CNT_W-1:0] TERM_HI = CNT_W'(1 << SWALLOW_W);

  logic [CNT_W-1:0] cnt;

  always_comb carry = (cnt >= ((mod_sel == MOD_HIGH) ? TERM_HI : TERM_LO));

  always_ff @(posedge clk) begin
    if (rst)        cnt <= '0;
    else if (carry) cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end

  // R3: the prescaler never counts beyond its long modulus
  p_cnt_range_r3: assert property (@(posedge clk) disable iff (rst)
    cnt <= TERM_HI);

  // R3: a carry always restarts the count
  p_carry_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    carry |=> (cnt == '0));
endmodule

// File: rtl/psd_swallow_ctrl.sv
module psd_swallow_ctrl
  import psd_pkg::*;
#(
  parameter int unsigned RATIO_W   = PSD_RATIO_W,
  parameter int unsigned SWALLOW_W = PSD_SWALLOW_W,
  parameter int unsigned MIN_RATIO = PSD_MIN_RATIO,
  localparam int unsigned M_W      = RATIO_W - SWALLOW_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               carry,
  input  logic               stg_valid,
  input  logic [RATIO_W-1:0] stg_ratio,
  output psd_mod_e           mod_sel,
  output logic               take,
  output logic               div_pulse
);
  localparam logic [RATIO_W-1:0] RST_RATIO = RATIO_W'(MIN_RATIO);

  logic [M_W-1:0]       m_left;
  logic [SWALLOW_W-1:0] a_left;
  logic [RATIO_W-1:0]   active;
  logic [RATIO_W-1:0]   next_ratio;
  logic                 boundary;
  logic                 pulse_q;

  always_comb begin
    boundary   = carry && (m_left == M_W'(1));
    next_ratio = stg_valid ? stg_ratio : active;
    take       = boundary && stg_valid;
    mod_sel    = (a_left != '0) ? MOD_HIGH : MOD_LOW;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= RST_RATIO;
      m_left  <= RST_RATIO[RATIO_W-1:SWALLOW_W];
      a_left  <= RST_RATIO[SWALLOW_W-1:0];
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= boundary;
      if (boundary) begin
        active <= next_ratio;
        m_left <= next_ratio[RATIO_W-1:SWALLOW_W];
        a_left <= next_ratio[SWALLOW_W-1:0];
      end else if (carry) begin
        m_left <= m_left - 1'b1;
        if (a_left != '0) a_left <= a_left - 1'b1;
      end
    end
  end

  assign div_pulse = pulse_q;

  // R2: the output pulse is exactly one clock wide
  p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    pulse_q |=> !pulse_q);

  // R7: the ratio in force changes only at a period boundary
  p_ratio_at_boundary_r7: assert property (@(posedge clk) disable iff (rst)
    (active != $past(active)) |-> $past(boundary));

  // R3: swallow cycles left never exceed main cycles left
  p_swallow_bound_r3: assert property (@(posedge clk) disable iff (rst)
    M_W'(a_left) <= m_left);

  // R8: main count stays non-zero, so every period has an end
  p_main_nonzero_r8: assert property (@(posedge clk) disable iff (rst)
    m_left != '0);
endmodule

// File: rtl/pswallow_div.sv
module pswallow_div
  import psd_pkg::*;
#(
  parameter int unsigned RATIO_W   = PSD_RATIO_W,
  parameter int unsigned LO_W      = PSD_LO_W,
  parameter int unsigned SWALLOW_W = PSD_SWALLOW_W,
  parameter int unsigned MIN_RATIO = PSD_MIN_RATIO
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    hi_wr,
  input  logic [RATIO_W-LO_W-1:0] hi_data,
  input  logic                    lo_wr,
  input  logic [LO_W-1:0]         lo_data,
  output logic                    div_pulse
);
  logic               stg_valid;
  logic [RATIO_W-1:0] stg_ratio;
  logic               take;
  logic               carry;
  psd_mod_e           mod_sel;

  psd_ratio_stage #(
    .RATIO_W(RATIO_W), .LO_W(LO_W), .MIN_RATIO(MIN_RATIO)
  ) u_stage (
    .clk(clk), .rst(rst),
    .hi_wr(hi_wr), .hi_data(hi_data),
    .lo_wr(lo_wr), .lo_data(lo_data),
    .take(take), .stg_valid(stg_valid), .stg_ratio(stg_ratio)
  );

  psd_prescaler #(
    .SWALLOW_W(SWALLOW_W)
  ) u_presc (
    .clk(clk), .rst(rst), .mod_sel(mod_sel), .carry(carry)
  );

  psd_swallow_ctrl #(
    .RATIO_W(RATIO_W), .SWALLOW_W(SWALLOW_W), .MIN_RATIO(MIN_RATIO)
  ) u_ctrl (
    .clk(clk), .rst(rst), .carry(carry),
    .stg_valid(stg_valid), .stg_ratio(stg_ratio),
    .mod_sel(mod_sel), .take(take), .div_pulse(div_pulse)
  );
endmodule

// File: tb/pswallow_div_bench.sv
module pswallow_div_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hi_wr = 1'b0;
  logic [6:0] hi_data = '0;
  logic       lo_wr = 1'b0;
  logic [7:0] lo_data = '0;
  logic       div_pulse;

  pswallow_div u_pswallow_div (
    .clk(clk), .rst(rst), .hi_wr(hi_wr), .hi_data(hi_data),
    .lo_wr(lo_wr), .lo_data(lo_data), .div_pulse(div_pulse)
  );

  always #5 clk = ~clk;

  int     n_cmp = 0;
  int     n_bad = 0;
  int     exp_q[$];
  string  tag_q[$];
  longint cyc = 0;
  longint last_evt = 0;
  int     iv;
  int     expv;
  string  etag;
  bit     prev_pulse = 1'b0;
  bit     done = 1'b0;

  // bench model of the staging rule
  int cur = 240;
  int bh = 0;
  int bl = 0;
  bit seen_h = 0;
  bit seen_l = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint ev);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, ev);
    end
  endtask

  function automatic int floor_of(input int v);
    return (v < 240) ? 240 : v;
  endfunction

  task automatic model_try();
    if (seen_h && seen_l) begin
      cur = floor_of(bh * 256 + bl);
      seen_h = 0;
      seen_l = 0;
    end
  endtask

  // monitor: measures pulse spacing and compares against the queue
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (rst) begin
        last_evt = cyc + 1;
        if (cyc == 2) chk(div_pulse == 1'b0, "R1 reset", div_pulse, 0);
      end else if (div_pulse) begin
        iv = int'(cyc - last_evt);
        last_evt = cyc;
        chk(!prev_pulse, "R2 width", prev_pulse, 0);
        if (exp_q.size() > 0) begin
          expv = exp_q.pop_front();
          etag = tag_q.pop_front();
          chk(iv == expv, etag, iv, expv);
        end
      end
      prev_pulse = div_pulse;
    end
  end

  task automatic wait_pulse();
    do @(negedge clk); while (!div_pulse);
  endtask

  task automatic write_now(input int v, input int mode);
    @(posedge clk); #1;
    case (mode)
      0: begin
        hi_wr = 1; hi_data = v[14:8]; lo_wr = 1; lo_data = v[7:0];
        bh = v[14:8]; seen_h = 1; bl = v[7:0]; seen_l = 1;
      end
      1: begin lo_wr = 1; lo_data = v[7:0]; bl = v[7:0]; seen_l = 1; end
      2, 3: begin hi_wr = 1; hi_data = v[14:8]; bh = v[14:8]; seen_h = 1; end
      default: begin lo_wr = 1; lo_data = v[7:0]; bl = v[7:0]; seen_l = 1; end
    endcase
    model_try();
    @(posedge clk); #1;
    hi_wr = 0; lo_wr = 0;
    if (mode == 1) begin
      hi_wr = 1; hi_data = v[14:8]; bh = v[14:8]; seen_h = 1;
      model_try();
      @(posedge clk); #1; hi_wr = 0;
    end else if (mode == 2) begin
      lo_wr = 1; lo_data = v[7:0]; bl = v[7:0]; seen_l = 1;
      model_try();
      @(posedge clk); #1; lo_wr = 0;
    end
  endtask

  // push the running period's spacing, then write during it
  task automatic set_ratio(input int v, input int mode, input string tag);
    wait_pulse();
    exp_q.push_back(cur);
    tag_q.push_back(tag);
    write_now(v, mode);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    exp_q.push_back(240); tag_q.push_back("R1 first period");
    repeat (4) @(posedge clk);
    #1 rst = 0;
    set_ratio(1000, 0, "R1 default 240");
    set_ratio(240, 1, "R2 N=1000 lo-then-hi R4");
    set_ratio(32767, 2, "R2 minimum 240");
    set_ratio(100, 0, "R9 maximum 32767 (R7 old period)");
    set_ratio(5000, 3, "R8 clamp 100->240");
    write_now(1234, 3);
    set_ratio(1234, 4, "R5 single byte keeps 240");
    set_ratio(0, 0, "R6 repeated upper byte N=1234");
    set_ratio(300, 0, "R8 clamp 0->240");
    write_now(16 * 20 + 15, 0);
    set_ratio(16 * 30, 2, "R7 later commit wins, A=15 R3");
    for (int k = 1; k <= 4; k++)
      set_ratio(240 + (k * 7919) % 2800, k % 3, "R3 A=0 / random N");
    wait_pulse();
    exp_q.push_back(cur); tag_q.push_back("R2 random N");
    wait_pulse();
    chk(exp_q.size() == 0, "R2 queue drained", exp_q.size(), 0);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R2 watchdog actual=%0d expected=%0d", exp_q.size(), 0);
      summary();
      $finish;
    end
  end
endmodule